// File: doc/BRIEF.md
# Event-Triggered Key Matrix Scanner

This block services a small key matrix of NROW rows and NCOL columns. The defaults are 5 by 5. Row drives are active low. The column returns are active low and are pulled high outside the block. While the block is idle it holds every row low. A closed switch then pulls its column low, so any press or release shows up as a change on the column inputs. The block stays quiet until it sees such a change. This keeps scan activity, and the noise it causes, away from the display while the keys are at rest.

Once started, the block steps a single low row across the matrix. Each row lasts a fixed number of bit-time ticks. At the end of each row slot the block records that row's switches into a key image of NROW*NCOL bits. When the first complete pass finishes, the block raises an interrupt. A host stop command returns the rows to the idle level and clears the interrupt. If a key changed during scanning before the stop arrived, that stop is used up without effect and the host has to issue a second one. A serial shifter outside the block reads the image.

Top module: `key_matrix_scanner`

## Requirements
- R1: After reset, every row output is low (row_n all 0), irq is 0 and key_img is all 0.
- R2: While idle, all rows stay low and irq stays 0 for as long as the column inputs do not change. A stop_cmd pulse in idle has no effect.
- R3: A press or a release seen on the columns while idle starts scanning. A row output goes high within 2 clock cycles of the column change.
- R4: While scanning, exactly one row is driven low at a time. The order is row index 0, 1, … NROW-1 and then back to 0, and each row lasts ROW_TICKS tick pulses.
- R5: irq rises at the end of the first complete row pass after start, never earlier. It then stays high while scanning continues.
- R6: At the end of the slot for row r, key_img bit r*NCOL+c (r and c counted from zero, so bit 0 is the first row and first column and bit 24 is the last of both) is written with 1 when column c reads low, meaning the switch is on, and with 0 otherwise.
- R7: An accepted stop_cmd drives all rows low and irq low on the next clock cycle, and the block returns to idle. A later column change starts scanning again.
- R8: If the key image changes during a pass after the first one, before a stop arrives, the next stop_cmd is ignored and scanning and irq continue. The stop after that one is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle bit-time pulse that paces the row slots |
| col_n | input | NCOL | Column returns, active low |
| stop_cmd | input | 1 | One-cycle stop request from the host interface |
| row_n | output | NROW | Row drives, active low while scanned, all low when idle |
| irq | output | 1 | Interrupt, high after the first full pass |
| key_img | output | NROW*NCOL | Key image, bit r*NCOL+c, 1 = switch on |

## Verification
A wrong row index or slot counter shows within one row slot as a row that goes low out of order or stays low for the wrong length, so the bench times every row transition. A wrong state or pending flag shows at the next stop command: the rows keep toggling when they should rest, or fall when a second stop should be needed. Those checks sample one cycle after the command. A corrupted image bit appears at the first interrupt, where the image is compared against the keys the bench holds.

// File: rtl/kms_pkg.sv
package kms_pkg;
    typedef enum logic [1:0] {
        KS_SETTLE = 2'd0,
        KS_IDLE   = 2'd1,
        KS_SCAN   = 2'd2
    } kscan_e;
endpackage

// File: rtl/kms_row_timer.sv
module kms_row_timer #(
    parameter int NROW      = 5,
    parameter int ROW_TICKS = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    tick,
    output logic [$clog2(NROW)-1:0] row_idx,
    output logic                    slot_end,
    output logic                    cycle_end
);
    localparam int RW = $clog2(NROW);
    localparam int TW = (ROW_TICKS > 1) ? $clog2(ROW_TICKS) : 1;
    localparam logic [RW-1:0] LAST_ROW  = RW'(NROW - 1);
    localparam logic [TW-1:0] LAST_TICK = TW'(ROW_TICKS - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic [RW-1:0] row;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d         = q;
        slot_end  = run && tick && (q.cnt == LAST_TICK);
        cycle_end = slot_end && (q.row == LAST_ROW);
        if (!run) begin
            d = '0;
        end else if (tick) begin
            if (slot_end) begin
                d.cnt = '0;
                d.row = (q.row == LAST_ROW) ? '0 : q.row + RW'(1);
            end else begin
                d.cnt = q.cnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign row_idx = q.row;

    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && row_idx != LAST_ROW) |=> (row_idx == $past(row_idx) + RW'(1))); // R4
    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> (row_idx == '0)); // R4
endmodule

// File: rtl/kms_change_det.sv
module kms_change_det #(
    parameter int NCOL = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [NCOL-1:0] col_n,
    output logic            changed
);
    logic [NCOL-1:0] held_q, held_d;

    always_comb begin
        held_d  = load ? col_n : held_q;
        changed = !load && (col_n != held_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '1;
        else        held_q <= held_d;
    end

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (load && $stable(col_n)) |=> !changed || !$stable(col_n)); // R2
endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner
    import kms_pkg::*;
#(
    parameter int NROW      = 5,
    parameter int NCOL      = 5,
    parameter int ROW_TICKS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [NCOL-1:0]        col_n,
    input  logic                   stop_cmd,
    output logic [NROW-1:0]        row_n,
    output logic                   irq,
    output logic [NROW*NCOL-1:0]   key_img
);
    localparam int NKEY = NROW * NCOL;
    localparam int RW   = $clog2(NROW);

    typedef struct packed {
        kscan_e          st;
        logic            irq;
        logic            done;
        logic            pend;
        logic [NKEY-1:0] img;
    } scan_t;

    scan_t q, d;

    logic [RW-1:0]   row_idx;
    logic            slot_end;
    logic            cycle_end;
    logic            changed;
    logic            chg;
    logic [NCOL-1:0] hits;

    kms_row_timer #(.NROW(NROW), .ROW_TICKS(ROW_TICKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (q.st == KS_SCAN),
        .tick      (tick),
        .row_idx   (row_idx),
        .slot_end  (slot_end),
        .cycle_end (cycle_end)
    );

    kms_change_det #(.NCOL(NCOL)) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (q.st == KS_SETTLE),
        .col_n   (col_n),
        .changed (changed)
    );

    always_comb begin
        d    = q;
        chg  = 1'b0;
        hits = ~col_n;
        case (q.st)
            KS_SETTLE: d.st = KS_IDLE;
            KS_IDLE: begin
                if (changed) begin
                    d.st   = KS_SCAN;
                    d.irq  = 1'b0;
                    d.done = 1'b0;
                    d.pend = 1'b0;
                end
            end
            KS_SCAN: begin
                if (slot_end) begin
                    chg = q.done && (q.img[int'(row_idx)*NCOL +: NCOL] != hits);
                    d.img[int'(row_idx)*NCOL +: NCOL] = hits;
                end
                if (cycle_end) begin
                    d.irq  = 1'b1;
                    d.done = 1'b1;
                end
                d.pend = (q.pend && !stop_cmd) || chg;
                if (stop_cmd && !q.pend) begin
                    d.st   = KS_SETTLE;
                    d.irq  = 1'b0;
                    d.done = 1'b0;
                    d.pend = 1'b0;
                end
            end
            default: d.st = KS_SETTLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= KS_SETTLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (q.st == KS_SCAN) row_n = ~(NROW'(1) << row_idx);
        else                 row_n = '0;
    end

    assign irq     = q.irq;
    assign key_img = q.img;

    AST_ONE_ROW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == KS_SCAN) |-> ($countones(~row_n) == 1)); // R4
    AST_START_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == KS_IDLE && changed) |=> (row_n != '0)); // R3
    AST_IRQ_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cycle_end)); // R5
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == KS_SCAN && stop_cmd && !q.pend) |=> (row_n == '0 && !irq)); // R7
    AST_STOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == KS_SCAN && stop_cmd && q.pend) |=> (row_n != '0)); // R8
endmodule

// File: tb/sim_key_matrix_scanner.sv
module sim_key_matrix_scanner;
    localparam int NR   = 5;
    localparam int NC   = 5;
    localparam int RT   = 4;
    localparam int TDIV = 2;
    localparam int SLOT = RT * TDIV;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick = 1'b0;
    logic [NC-1:0]   col_n;
    logic            stop_cmd = 1'b0;
    logic [NR-1:0]   row_n;
    logic            irq;
    logic [NR*NC-1:0] key_img;
    logic [NR*NC-1:0] keys = '0;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    key_matrix_scanner #(.NROW(NR), .NCOL(NC), .ROW_TICKS(RT)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .col_n(col_n),
        .stop_cmd(stop_cmd), .row_n(row_n), .irq(irq), .key_img(key_img)
    );

    // passive matrix: a closed switch pulls its column low when its row is low
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            col_n[c] = 1'b1;
            for (int r = 0; r < NR; r++)
                if (keys[r*NC+c] && !row_n[r]) col_n[c] = 1'b0;
        end
    end

    initial begin
        forever begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_pulse();
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; keys = '0;
        cyc(3);
        chk(row_n == '0, "R1 rows", 32'(row_n), 0);
        chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
        chk(key_img == '0, "R1 image", 32'(key_img), 0);
        rst_n = 1'b1;
        cyc(2);
    endtask

    task automatic t_idle();
        cyc(60);
        chk(row_n == '0 && irq == 1'b0, "R2 quiet idle", 32'(row_n), 0);
        stop_pulse();
        cyc(5);
        chk(row_n == '0 && irq == 1'b0, "R2 stop in idle", 32'(row_n), 0);
    endtask

    task automatic t_press();
        keys[8] = 1'b1;
        cyc(2);
        chk(row_n != '0, "R3 press starts", 32'(row_n), 32'h1e);
        cyc(25);
        chk(irq == 1'b0, "R5 irq not early", 32'(irq), 0);
        cyc(23);
        chk(irq == 1'b1, "R5 irq after pass", 32'(irq), 1);
        chk(key_img == 25'(1 << 8), "R6 single key", 32'(key_img), 32'(1 << 8));
        stop_pulse();
        chk(row_n == '0 && irq == 1'b0, "R7 stop releases", {irq, 27'd0, row_n}, 0);
        cyc(30);
        chk(row_n == '0, "R7 held key no restart", 32'(row_n), 0);
    endtask

    task automatic t_release();
        keys[8] = 1'b0;
        cyc(2);
        chk(row_n != '0, "R3 release starts", 32'(row_n), 32'h1e);
        cyc(48);
        chk(irq == 1'b1, "R5 irq stays high", 32'(irq), 1);
        chk(key_img == '0, "R6 released image", 32'(key_img), 0);
        stop_pulse();
        chk(row_n == '0, "R7 second session stop", 32'(row_n), 0);
        cyc(4);
    endtask

    task automatic t_order_and_pending();
        logic [NR-1:0] prev;
        int n;
        keys = '0;
        keys[0] = 1'b1; keys[12] = 1'b1; keys[24] = 1'b1;
        cyc(2);
        chk(row_n == 5'b11110, "R4 first row", 32'(row_n), 32'h1e);
        for (int i = 1; i <= 6; i++) begin
            prev = row_n;
            n = 0;
            while (row_n == prev && n < 100) begin
                @(negedge clk); n++;
            end
            chk(row_n == ~NR'(1 << (i % NR)), "R4 row order", 32'(row_n), 32'(~NR'(1 << (i % NR))));
            if (i > 1) chk(n == SLOT, "R4 slot length", n, SLOT);
        end
        chk(irq == 1'b1, "R5 irq in scan", 32'(irq), 1);
        chk(key_img == 25'h1001001, "R6 corner keys", 32'(key_img), 32'h1001001);
        keys[5] = 1'b1;
        cyc(50);
        chk(key_img == 25'h1001021, "R6 added key", 32'(key_img), 32'h1001021);
        stop_pulse();
        cyc(2);
        chk(row_n != '0 && irq == 1'b1, "R8 first stop ignored", {irq, 27'd0, row_n}, 1);
        cyc(3);
        stop_pulse();
        chk(row_n == '0 && irq == 1'b0, "R8 second stop accepted", {irq, 27'd0, row_n}, 0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_press();
        t_release();
        t_order_and_pending();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule